// File: doc/BRIEF.md
# Serial Eight-Channel ADC Conversion Controller

This controller runs one complete conversion on an external 12-bit serial converter that has eight multiplexed inputs. The host raises a request together with a 3-bit channel number while the block is idle. The block first sends a 5-bit control word to the converter over a serial link, framed by an active-low transmit sync. The word carries the channel address, a conversion-start bit and a power-down bit, and both of those bits are sent as 0.

After the word is sent, the block waits out the converter's post-address blanking interval. It then pulses the active-low conversion-start strobe and allows a fixed conversion time to pass. Next it clocks in a 16-bit result frame under an active-low receive sync. That frame holds a leading zero, a 3-bit channel echo and 12 data bits, all sent MSB first. The block then presents the channel, the sample and an error flag with a one-cycle valid pulse.

The serial clock idles high and is made from the system clock. Each half period lasts `CLK_DIV` system clocks. Incoming data is sampled on falling serial-clock edges. Outgoing control bits change only while the serial clock is high.

Top module: `adc_serial_ctrl`

## Requirements
- R1: While reset is high and right after it, `busy` and `res_valid` are 0, `adc_sclk`, `adc_tfs_n`, `adc_rfs_n` and `adc_conv_n` are all 1.
- R2: A request is accepted only when `req_valid` is 1 while `busy` is 0. A request raised while busy is ignored: it starts no control frame and does not alter the channel of the transaction in flight.
- R3: The control frame holds `adc_tfs_n` low for exactly 5 falling `adc_sclk` edges. The bits sampled on those edges are, in order, channel bit 2, bit 1, bit 0, conversion-start (0), power-down (0).
- R4: Exactly `BLANK_CYCLES` system clocks separate the end of the control frame (`adc_tfs_n` back high) from the fall of `adc_conv_n`.
- R5: `adc_conv_n` goes low for exactly `PULSE_W` system clocks. It is never low while either frame sync is low.
- R6: Exactly `CONV_CYCLES` system clocks after `adc_conv_n` returns high, `adc_rfs_n` falls. It then stays low for exactly 16 falling `adc_sclk` edges.
- R7: Of the 16 received bits, the first is the leading bit, bits 2 to 4 are the channel (MSB first) and bits 5 to 16 are the 12-bit sample (MSB first). These appear on `res_chan` and `res_data`.
- R8: `res_err` is 1 with the result exactly when the received leading bit was 1, and 0 when it was 0.
- R9: `busy` rises in the cycle after acceptance and stays high until the cycle of `res_valid`, in which it is already 0. `res_valid` lasts one cycle and occurs once per accepted request.
- R10: While a frame is active, each `adc_sclk` level lasts exactly `CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request |
| req_chan | input | 3 | Channel to convert |
| busy | output | 1 | Transaction in flight |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 3 | Channel echoed in the result frame |
| res_data | output | 12 | Converted sample |
| res_err | output | 1 | Leading bit of result frame was 1 |
| adc_sclk | output | 1 | Serial clock to converter, idles high |
| adc_tfs_n | output | 1 | Active-low control frame sync |
| adc_dout | output | 1 | Control word serial data to converter |
| adc_conv_n | output | 1 | Active-low conversion-start strobe |
| adc_rfs_n | output | 1 | Active-low result frame sync |
| adc_din | input | 1 | Result serial data from converter |

## Verification
`busy` is due one clock after the edge that samples an accepted request. `res_valid` is due on the same edge that lifts `adc_rfs_n`, so the bench keeps an expected-busy model that it updates from those two events and compares on every falling clock. The blanking, strobe width and conversion wait are counted in falling-clock samples from the edge that ends the preceding phase, and they must equal `BLANK_CYCLES`, `PULSE_W` and `CONV_CYCLES` exactly. A behavioural converter model captures the control word and drives the result frame on serial-clock edges, and every serial-clock half period is counted against `CLK_DIV`.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    localparam int CH_W    = 3;
    localparam int DATA_W  = 12;
    localparam int CTRL_W  = CH_W + 2;
    localparam int FRAME_W = 1 + CH_W + DATA_W;
    localparam int BITS_W  = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_BLANK,
        ST_CONV,
        ST_WAIT,
        ST_RX
    } adcif_state_e;

    typedef struct packed {
        logic              err;
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] data;
    } adcif_result_t;

    // control word: address bits, start bit, power-down bit
    function automatic logic [CTRL_W-1:0] make_ctrl(input logic [CH_W-1:0] ch);
        return {ch, 1'b0, 1'b0};
    endfunction

    function automatic adcif_result_t parse_frame(input logic [FRAME_W-1:0] f);
        adcif_result_t r;
        r.err  = f[FRAME_W-1];
        r.chan = f[FRAME_W-2 -: CH_W];
        r.data = f[DATA_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/adcif_sclk_eng.sv
module adcif_sclk_eng
    import adcif_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BITS_W-1:0] nbits,
    output logic              sclk,
    output logic              frame_act,
    output logic              fall_stb,
    output logic              rise_stb,
    output logic              done
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);

    logic [DIV_W-1:0]  div_q;
    logic [BITS_W-1:0] bit_q;
    logic [BITS_W-1:0] nbits_q;
    logic              run_q;
    logic              sclk_q;
    logic              half_end;
    logic              last_bit;

    assign half_end = run_q && (div_q == DIV_W'(CLK_DIV - 1));
    assign last_bit = (bit_q == nbits_q - BITS_W'(1));
    assign fall_stb = half_end && sclk_q;
    assign rise_stb = half_end && !sclk_q && !last_bit;
    assign done     = half_end && !sclk_q && last_bit;
    assign sclk      = sclk_q;
    assign frame_act = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            sclk_q  <= 1'b1;
            div_q   <= '0;
            bit_q   <= '0;
            nbits_q <= '0;
        end else if (start && !run_q) begin
            run_q   <= 1'b1;
            sclk_q  <= 1'b1;
            div_q   <= '0;
            bit_q   <= '0;
            nbits_q <= nbits;
        end else if (run_q) begin
            if (half_end) begin
                div_q <= '0;
                if (sclk_q) begin
                    sclk_q <= 1'b0;
                end else begin
                    sclk_q <= 1'b1;
                    if (last_bit) run_q <= 1'b0;
                    else          bit_q <= bit_q + BITS_W'(1);
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    // R10
    half_period_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !half_end) |=> $stable(sclk_q));

    // R3
    bit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (bit_q < nbits_q));

endmodule

// File: rtl/adcif_tx_shift.sv
module adcif_tx_shift
    import adcif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CTRL_W-1:0] word,
    input  logic              shift,
    output logic              dout
);
    logic [CTRL_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)        sr_q <= '0;
        else if (load)  sr_q <= word;
        else if (shift) sr_q <= {sr_q[CTRL_W-2:0], 1'b0};
    end

    assign dout = sr_q[CTRL_W-1];

endmodule

// File: rtl/adcif_rx_shift.sv
module adcif_rx_shift
    import adcif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sample,
    input  logic               din,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)         sr_q <= '0;
        else if (sample) sr_q <= {sr_q[FRAME_W-2:0], din};
    end

    assign frame = sr_q;

endmodule

// File: rtl/adcif_seq.sv
module adcif_seq
    import adcif_pkg::*;
#(
    parameter int BLANK_CYCLES = 6,
    parameter int PULSE_W      = 2,
    parameter int CONV_CYCLES  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              eng_done,
    output adcif_state_e      state,
    output logic              accept,
    output logic              eng_start,
    output logic [BITS_W-1:0] eng_nbits,
    output logic              conv_n,
    output logic              capture
);
    localparam int MAX_A = (BLANK_CYCLES > PULSE_W) ? BLANK_CYCLES : PULSE_W;
    localparam int MAX_W = (MAX_A > CONV_CYCLES) ? MAX_A : CONV_CYCLES;
    localparam int CNT_W = $clog2(MAX_W + 1);

    adcif_state_e     st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             conv_n_q;
    logic             wait_end;

    assign state     = st_q;
    assign accept    = (st_q == ST_IDLE) && req_valid;
    assign wait_end  = (st_q == ST_WAIT) && (cnt_q == CNT_W'(CONV_CYCLES - 1));
    assign eng_start = accept || wait_end;
    assign eng_nbits = (st_q == ST_IDLE) ? BITS_W'(CTRL_W) : BITS_W'(FRAME_W);
    assign capture   = (st_q == ST_RX) && eng_done;
    assign conv_n    = conv_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            conv_n_q <= 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) st_q <= ST_TX;
                ST_TX: if (eng_done) begin
                    st_q  <= ST_BLANK;
                    cnt_q <= '0;
                end
                ST_BLANK: if (cnt_q == CNT_W'(BLANK_CYCLES - 1)) begin
                    st_q     <= ST_CONV;
                    cnt_q    <= '0;
                    conv_n_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                ST_CONV: if (cnt_q == CNT_W'(PULSE_W - 1)) begin
                    st_q     <= ST_WAIT;
                    cnt_q    <= '0;
                    conv_n_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                ST_WAIT: if (wait_end) begin
                    st_q  <= ST_RX;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                ST_RX: if (eng_done) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R5
    strobe_state_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_n_q |-> (st_q == ST_CONV));

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
    import adcif_pkg::*;
#(
    parameter int CLK_DIV      = 2,
    parameter int BLANK_CYCLES = 6,
    parameter int PULSE_W      = 2,
    parameter int CONV_CYCLES  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    output logic              busy,
    output logic              res_valid,
    output logic [CH_W-1:0]   res_chan,
    output logic [DATA_W-1:0] res_data,
    output logic              res_err,
    output logic              adc_sclk,
    output logic              adc_tfs_n,
    output logic              adc_dout,
    output logic              adc_conv_n,
    output logic              adc_rfs_n,
    input  logic              adc_din
);
    adcif_state_e       state;
    logic               accept;
    logic               eng_start;
    logic [BITS_W-1:0]  eng_nbits;
    logic               eng_done;
    logic               frame_act;
    logic               fall_stb;
    logic               rise_stb;
    logic               capture;
    logic [FRAME_W-1:0] rx_frame;
    adcif_result_t      res_q;
    logic               valid_q;

    adcif_seq #(
        .BLANK_CYCLES(BLANK_CYCLES),
        .PULSE_W     (PULSE_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .eng_done (eng_done),
        .state    (state),
        .accept   (accept),
        .eng_start(eng_start),
        .eng_nbits(eng_nbits),
        .conv_n   (adc_conv_n),
        .capture  (capture)
    );

    adcif_sclk_eng #(.CLK_DIV(CLK_DIV)) eng_i (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .nbits    (eng_nbits),
        .sclk     (adc_sclk),
        .frame_act(frame_act),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .done     (eng_done)
    );

    adcif_tx_shift tx_i (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .word (make_ctrl(req_chan)),
        .shift(rise_stb && (state == ST_TX)),
        .dout (adc_dout)
    );

    adcif_rx_shift rx_i (
        .clk   (clk),
        .rst   (rst),
        .sample(fall_stb && (state == ST_RX)),
        .din   (adc_din),
        .frame (rx_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= capture;
            if (capture) res_q <= parse_frame(rx_frame);
        end
    end

    assign busy      = (state != ST_IDLE);
    assign adc_tfs_n = !(frame_act && (state == ST_TX));
    assign adc_rfs_n = !(frame_act && (state == ST_RX));
    assign res_valid = valid_q;
    assign res_chan  = res_q.chan;
    assign res_data  = res_q.data;
    assign res_err   = res_q.err;

    // R2
    frame_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_tfs_n) |-> $past(req_valid && !busy));

    // R5
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !adc_conv_n |-> (adc_tfs_n && adc_rfs_n));

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R9
    valid_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !busy);

endmodule

// File: tb/adc_serial_ctrl_tb_top.sv
module adc_serial_ctrl_tb_top;
    localparam int CLK_DIV      = 2;
    localparam int BLANK_CYCLES = 6;
    localparam int PULSE_W      = 2;
    localparam int CONV_CYCLES  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_chan = '0;
    logic        busy, res_valid, res_err;
    logic [2:0]  res_chan;
    logic [11:0] res_data;
    logic        adc_sclk, adc_tfs_n, adc_dout, adc_conv_n, adc_rfs_n;
    logic        adc_din = 1'b0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    adc_serial_ctrl #(
        .CLK_DIV(CLK_DIV), .BLANK_CYCLES(BLANK_CYCLES),
        .PULSE_W(PULSE_W), .CONV_CYCLES(CONV_CYCLES)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
        .busy(busy), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .res_err(res_err), .adc_sclk(adc_sclk),
        .adc_tfs_n(adc_tfs_n), .adc_dout(adc_dout), .adc_conv_n(adc_conv_n),
        .adc_rfs_n(adc_rfs_n), .adc_din(adc_din)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // transaction expectations
    logic [2:0]  exp_chan = '0;
    logic [11:0] exp_data = '0;
    logic        exp_lead = 1'b0;
    logic [15:0] tx_frame = '0;
    int          frames_tx = 0;
    int          results = 0;

    // converter model: control capture
    logic [4:0] ctl_word = '0;
    int         ctl_bits = 0;
    int         rx_falls = 0;
    int         tx_idx = 0;

    always @(negedge adc_sclk) begin
        if (!rst && !adc_tfs_n) begin
            ctl_word = {ctl_word[3:0], adc_dout};
            ctl_bits++;
        end
        if (!rst && !adc_rfs_n) rx_falls++;
    end

    always @(posedge adc_tfs_n) begin
        if (!rst) begin
            chk(ctl_bits == 5, "R3 ctrl bit count", ctl_bits, 5);
            chk(ctl_word == {exp_chan, 2'b00}, "R3 ctrl word", ctl_word, {exp_chan, 2'b00});
            frames_tx++;
            tx_frame = {exp_lead, ctl_word[4:2], exp_data};
        end
        ctl_bits = 0;
    end

    always @(negedge adc_rfs_n) begin
        tx_idx  = 15;
        adc_din = tx_frame[15];
    end

    always @(posedge adc_sclk) begin
        if (!adc_rfs_n && tx_idx > 0) begin
            tx_idx  = tx_idx - 1;
            adc_din = tx_frame[tx_idx];
        end
    end

    always @(posedge adc_rfs_n) begin
        if (!rst) chk(rx_falls == 16, "R6 result bit count", rx_falls, 16);
        rx_falls = 0;
    end

    // per-clock reference model
    logic acc_pending = 1'b0;
    logic busy_obs = 1'b0;
    logic exp_busy = 1'b0;
    logic prev_sclk = 1'b1;
    logic prev_fr = 1'b0;
    logic prev_tfs = 1'b1;
    logic prev_conv = 1'b1;
    int   half_cnt = 0;
    int   phase = 0;
    int   ph_cnt = 0;

    always @(posedge clk) acc_pending <= req_valid && !busy_obs && !rst;

    always @(negedge clk) begin
        if (!rst) begin
            logic fr;
            if (acc_pending) exp_busy = 1'b1;
            if (res_valid) begin
                chk(exp_busy, "R9 valid without request", 0, 1);
                exp_busy = 1'b0;
                results++;
            end
            chk(busy == exp_busy, "R9 busy", busy, exp_busy);

            fr = !adc_tfs_n || !adc_rfs_n;
            if (fr && !prev_fr) half_cnt = 1;
            else if (fr) begin
                if (adc_sclk != prev_sclk) begin
                    chk(half_cnt == CLK_DIV, "R10 half period", half_cnt, CLK_DIV);
                    half_cnt = 1;
                end else half_cnt++;
            end

            // phase: 1 blank, 2 strobe, 3 conversion wait
            if (adc_tfs_n && !prev_tfs) begin phase = 1; ph_cnt = 0; end
            case (phase)
                1: if (adc_conv_n) ph_cnt++;
                   else begin
                       chk(ph_cnt == BLANK_CYCLES, "R4 blanking", ph_cnt, BLANK_CYCLES);
                       phase = 2; ph_cnt = 1;
                   end
                2: if (!adc_conv_n) ph_cnt++;
                   else begin
                       chk(ph_cnt == PULSE_W, "R5 strobe width", ph_cnt, PULSE_W);
                       phase = 3; ph_cnt = 1;
                   end
                3: if (adc_rfs_n) ph_cnt++;
                   else begin
                       chk(ph_cnt == CONV_CYCLES, "R6 conversion wait", ph_cnt, CONV_CYCLES);
                       phase = 0;
                   end
                default: ;
            endcase
            if (!adc_conv_n && prev_conv && phase != 2)
                chk(0, "R5 strobe outside sequence", 0, 1);
            prev_fr   = fr;
            prev_sclk = adc_sclk;
            prev_tfs  = adc_tfs_n;
            prev_conv = adc_conv_n;
        end
        busy_obs = busy;
    end

    task automatic run_txn(input logic [2:0] ch, input logic [11:0] data,
                           input logic lead, input bit spam);
        int guard;
        exp_chan = ch;
        exp_data = data;
        exp_lead = lead;
        @(negedge clk);
        req_valid = 1'b1;
        req_chan  = ch;
        @(negedge clk);
        req_valid = 1'b0;
        if (spam) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1;
            req_chan  = ~ch;
            repeat (40) @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (!res_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(res_valid == 1'b1, "R9 result arrives", res_valid, 1);
        chk(res_chan == ch, "R7 channel", res_chan, ch);
        chk(res_data == data, "R7 sample", res_data, data);
        chk(res_err == lead, "R8 error flag", res_err, lead);
        @(negedge clk);
        chk(res_valid == 1'b0, "R9 single pulse", res_valid, 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 during reset
        chk(!busy && !res_valid, "R1 reset outputs", {busy, res_valid}, 0);
        chk(adc_sclk && adc_tfs_n && adc_rfs_n && adc_conv_n, "R1 reset idle pins",
            {adc_sclk, adc_tfs_n, adc_rfs_n, adc_conv_n}, 4'hf);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && adc_tfs_n && adc_conv_n, "R1 after reset", {busy, adc_tfs_n, adc_conv_n}, 3'b011);

        run_txn(3'd0, 12'h000, 1'b0, 0);
        run_txn(3'd7, 12'hfff, 1'b0, 0);
        run_txn(3'd5, 12'ha5a, 1'b0, 0);
        run_txn(3'd2, 12'h5a5, 1'b1, 0);   // R8 leading one
        run_txn(3'd3, 12'h123, 1'b0, 1);   // R2 requests while busy
        run_txn(3'd4, 12'h800, 1'b0, 0);
        run_txn(3'd1, 12'h001, 1'b1, 0);

        repeat (20) @(negedge clk);
        // R2 only accepted requests produce frames and results
        chk(frames_tx == 7, "R2 frame count", frames_tx, 7);
        chk(results == 7, "R2 result count", results, 7);
        chk(!busy, "R2 idle after run", busy, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule